// File: doc/BRIEF.md
# Multi-Queue First-Word-Fall-Through Read Controller

This block stores eight independent logical queues of 18-bit words in one shared memory. Writes go to one queue at a time, chosen by a write address that is latched with a write-address strobe. Reads come from one queue at a time, chosen by a read address that is latched with a read-address strobe. The read side presents words without being asked. The head of the selected queue moves to the output register on its own, and a read-enable pulse only consumes the word already shown.

Both addresses hold a queue number in their low bits and a device number in their high bits. Several copies of the block, each with its own `DEV_ID`, can therefore sit on one read bus. Only the copy whose number matches the latched read address drives the bus; the others output zeros and set their drive-enable low, so the bus can be formed by OR-ing the copies. An active-high stale flag tells whether the word on the bus has already been taken. One clock and a synchronous active-high reset are used.

Top module: `mq_fwft_reader`

## Requirements
- R1: After reset, `q_data` is zero, the read and write selections point at queue 0 of device 0, `q_drive` is high when `DEV_ID` is 0, and `out_stale` is high while driven.
- R2: An address is `{device[DEV_W-1:0], queue[2:0]}`, with the queue number in bits 2:0. A write-address strobe latches the write address. `wr_en` appends `wr_data` to the latched queue only when the latched device equals `DEV_ID`; otherwise the write has no effect.
- R3: Each queue holds at most `DEPTH` words. A write to a full queue is dropped, so exactly `DEPTH` words can be read back from it.
- R4: Each queue returns its words in the order they were written, independent of traffic to the other queues.
- R5: When the read address is latched at clock edge E0, the selected queue's head word appears on `q_data` after edge E0+2, with `out_stale` low, even if `rd_en` is low. `rd_en` has no effect at edges E0+1 and E0+2.
- R6: A `rd_en` edge that consumes the last word of the selected queue raises `out_stale` after that edge and leaves `q_data` unchanged.
- R7: While the selected queue stays empty, `out_stale` stays high and `q_data` keeps the last word.
- R8: A write into the selected queue while `out_stale` is high shows that word on the next clock edge, with `out_stale` low, and needs no `rd_en`.
- R9: With `rd_en` low, no queue switch pending and `out_stale` low, `q_data` does not change.
- R10: When the latched read device differs from `DEV_ID`, `q_drive` is low, `q_data` and `out_stale` are zero, and `rd_en` removes no words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_addr_en | input | 1 | Latch `wr_addr` as the write selection |
| wr_addr | input | DEV_W+3 | Write address {device, queue} |
| wr_en | input | 1 | Append `wr_data` to the write-selected queue |
| wr_data | input | DATA_W | Word to write |
| rd_addr_en | input | 1 | Latch `rd_addr` and start a queue switch |
| rd_addr | input | DEV_W+3 | Read address {device, queue} |
| rd_en | input | 1 | Consume the word on `q_data` |
| q_data | output | DATA_W | Presented word, zero when not driving |
| q_drive | output | 1 | This instance owns the read bus |
| out_stale | output | 1 | High: the presented word was already consumed |

## Verification
A wrong pointer or a bad full or empty decision does not show up at once. It appears only when the damaged queue is selected and drained, as a word out of order, a missing word, or an extra word past `DEPTH`. The random phase therefore compares every cycle against a queue model and drains queues often. A wrong switch phase shows within three edges of a read-address strobe, because the new head arrives one cycle early or late. A wrong device match shows at once on `q_drive`, and shows later as words lost while the instance was deselected.

// File: rtl/mqf_pkg.sv
package mqf_pkg;
  // Phase of a read-queue switch: strobe -> wait -> load -> idle
  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_WAIT = 2'd1,
    SW_LOAD = 2'd2
  } sw_phase_e;
endpackage

// File: rtl/mqf_ptrs.sv
module mqf_ptrs #(
  parameter int NQ    = 8,
  parameter int DEPTH = 16,
  localparam int QW = $clog2(NQ),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [QW-1:0] push_q,
  input  logic          pop,
  input  logic [QW-1:0] pop_q,
  output logic [QW+PW-1:0] wr_slot,
  output logic [QW+PW-1:0] rd_slot,
  output logic          full_w,
  output logic          empty_r
);
  logic [PW:0] wp_a [NQ];
  logic [PW:0] rp_a [NQ];

  // One write and one read pointer per queue, with a wrap bit
  for (genvar g = 0; g < NQ; g++) begin : g_q
    logic [PW:0] wp, rp;
    always_ff @(posedge clk) begin
      if (rst) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push && push_q == QW'(g)) wp <= wp + 1'b1;
        if (pop && pop_q == QW'(g))   rp <= rp + 1'b1;
      end
    end
    assign wp_a[g] = wp;
    assign rp_a[g] = rp;
  end

  logic [PW:0] wsel_w, wsel_r, rsel_w, rsel_r;
  assign wsel_w = wp_a[push_q];
  assign wsel_r = rp_a[push_q];
  assign rsel_w = wp_a[pop_q];
  assign rsel_r = rp_a[pop_q];

  assign wr_slot = {push_q, wsel_w[PW-1:0]};
  assign rd_slot = {pop_q, rsel_r[PW-1:0]};
  assign full_w  = (wsel_w ^ wsel_r) == {1'b1, {PW{1'b0}}};
  assign empty_r = (rsel_w == rsel_r);
endmodule

// File: rtl/mqf_store.sv
module mqf_store #(
  parameter int DATA_W = 18,
  parameter int AW     = 7,
  localparam int WORDS = 2 ** AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Registered read port with read enable; doubles as the output register
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/mqf_rdctl.sv
module mqf_rdctl
  import mqf_pkg::*;
#(
  parameter int NQ     = 8,
  parameter int DEV_W  = 2,
  parameter int DEV_ID = 0,
  localparam int QW     = $clog2(NQ),
  localparam int ADDR_W = DEV_W + QW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_addr_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  input  logic              empty_r,
  output logic [QW-1:0]     rq,
  output logic              hit,
  output logic              pop,
  output logic              stale
);
  sw_phase_e phase;
  logic      act;

  // act: the output register is due for an update this edge
  always_comb begin
    act = 1'b0;
    if (hit) begin
      unique case (phase)
        SW_LOAD: act = 1'b1;
        SW_IDLE: act = stale | rd_en;
        default: act = 1'b0;
      endcase
    end
  end

  assign pop = act & ~empty_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= SW_IDLE;
      rq    <= '0;
      hit   <= (DEV_ID == 0);
      stale <= 1'b1;
    end else begin
      if (act) stale <= empty_r;
      if (rd_addr_en) begin
        rq    <= rd_addr[QW-1:0];
        hit   <= (rd_addr[ADDR_W-1:QW] == DEV_W'(DEV_ID));
        phase <= SW_WAIT;
      end else begin
        unique case (phase)
          SW_WAIT: phase <= SW_LOAD;
          default: phase <= SW_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mq_fwft_reader.sv
module mq_fwft_reader #(
  parameter int DATA_W = 18,
  parameter int NQ     = 8,
  parameter int DEPTH  = 16,
  parameter int DEV_W  = 2,
  parameter int DEV_ID = 0,
  localparam int QW     = $clog2(NQ),
  localparam int PW     = $clog2(DEPTH),
  localparam int ADDR_W = DEV_W + QW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_addr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_addr_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_en,
  output logic [DATA_W-1:0] q_data,
  output logic              q_drive,
  output logic              out_stale
);
  logic [QW-1:0]    wq;
  logic             whit;
  logic [QW-1:0]    rq;
  logic             rhit, pop, stale, push, full_w, empty_r;
  logic [QW+PW-1:0] wr_slot, rd_slot;
  logic [DATA_W-1:0] rdata;

  // Write selection register
  always_ff @(posedge clk) begin
    if (rst) begin
      wq   <= '0;
      whit <= (DEV_ID == 0);
    end else if (wr_addr_en) begin
      wq   <= wr_addr[QW-1:0];
      whit <= (wr_addr[ADDR_W-1:QW] == DEV_W'(DEV_ID));
    end
  end

  assign push = wr_en & whit & ~full_w;

  mqf_ptrs #(.NQ(NQ), .DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst(rst),
    .push(push), .push_q(wq),
    .pop(pop), .pop_q(rq),
    .wr_slot(wr_slot), .rd_slot(rd_slot),
    .full_w(full_w), .empty_r(empty_r)
  );

  mqf_store #(.DATA_W(DATA_W), .AW(QW + PW)) u_store (
    .clk(clk), .rst(rst),
    .we(push), .waddr(wr_slot), .wdata(wr_data),
    .re(pop), .raddr(rd_slot), .rdata(rdata)
  );

  mqf_rdctl #(.NQ(NQ), .DEV_W(DEV_W), .DEV_ID(DEV_ID)) u_rdctl (
    .clk(clk), .rst(rst),
    .rd_addr_en(rd_addr_en), .rd_addr(rd_addr), .rd_en(rd_en),
    .empty_r(empty_r),
    .rq(rq), .hit(rhit), .pop(pop), .stale(stale)
  );

  // Released outputs read as zero so shared buses can be OR-combined
  assign q_drive   = rhit;
  assign q_data    = rhit ? rdata : '0;
  assign out_stale = rhit & stale;
endmodule

// File: rtl/mqf_chk.sv
module mqf_chk #(
  parameter int DATA_W = 18,
  parameter int QW     = 3,
  parameter int DEV_W  = 2,
  parameter int DEV_ID = 0,
  localparam int ADDR_W = DEV_W + QW
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_addr_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_en,
  input logic [DATA_W-1:0] q_data,
  input logic              q_drive,
  input logic              out_stale
);
  // R1: a reset edge clears the word and leaves it marked as stale
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (q_data == '0 && out_stale == q_drive));

  // R5: the edge after a strobe never changes the word
  a_r5_switch_wait: assert property (@(posedge clk) disable iff (rst)
    rd_addr_en ##1 !rd_addr_en |=> $stable(q_data));

  // R6: the stale flag rises without the word changing
  a_r6_stale_keeps_word: assert property (@(posedge clk) disable iff (rst)
    ($rose(out_stale) && $past(q_drive) && q_drive) |-> $stable(q_data));

  // R9: no read, no pending switch, fresh word -> word holds
  a_r9_hold_word: assert property (@(posedge clk) disable iff (rst)
    (q_drive && !out_stale && !rd_en && !rd_addr_en &&
     !$past(rd_addr_en) && !$past(rd_addr_en, 2)) |=> $stable(q_data));

  // R10: a foreign device number in the latched read address releases the bus
  a_r10_release: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(rd_addr_en) &&
     ($past(rd_addr[ADDR_W-1:QW]) != DEV_W'(DEV_ID))) |-> !q_drive);
endmodule

bind mq_fwft_reader mqf_chk #(
  .DATA_W(DATA_W), .QW(QW), .DEV_W(DEV_W), .DEV_ID(DEV_ID)
) u_chk (
  .clk(clk), .rst(rst), .rd_addr_en(rd_addr_en), .rd_addr(rd_addr),
  .rd_en(rd_en), .q_data(q_data), .q_drive(q_drive), .out_stale(out_stale)
);

// File: tb/tb_mq_fwft_reader.sv
module tb_mq_fwft_reader;
  localparam int CLK_P  = 10;
  localparam int DATA_W = 18;
  localparam int NQ     = 8;
  localparam int DEPTH  = 16;
  localparam int DEV_W  = 2;
  localparam int QW     = 3;
  localparam int ADDR_W = DEV_W + QW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_addr_en = 0, wr_en = 0, rd_addr_en = 0, rd_en = 0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] q_data;
  logic q_drive, out_stale;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  mq_fwft_reader #(.DATA_W(DATA_W), .NQ(NQ), .DEPTH(DEPTH), .DEV_W(DEV_W), .DEV_ID(0)) dut (
    .clk(clk), .rst(rst), .wr_addr_en(wr_addr_en), .wr_addr(wr_addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_addr_en(rd_addr_en), .rd_addr(rd_addr), .rd_en(rd_en),
    .q_data(q_data), .q_drive(q_drive), .out_stale(out_stale)
  );

  // Reference model state, built from the requirements
  logic [DATA_W-1:0] mq [NQ][$];
  logic [ADDR_W-1:0] m_wa;
  logic [QW-1:0]     m_rq;
  logic              m_hit, m_stale;
  int                m_phase;
  logic [DATA_W-1:0] m_dout;

  task automatic model_reset();
    for (int i = 0; i < NQ; i++) mq[i].delete();
    m_wa = '0; m_rq = '0; m_hit = 1'b1; m_stale = 1'b1; m_phase = 0; m_dout = '0;
  endtask

  task automatic model_edge();
    logic emp, act, whit, wful;
    logic [QW-1:0] wq;
    wq   = m_wa[QW-1:0];
    emp  = (mq[m_rq].size() == 0);
    act  = m_hit && ((m_phase == 2) || (m_phase == 0 && (m_stale || rd_en)));
    whit = (m_wa[ADDR_W-1:QW] == '0);
    wful = (mq[wq].size() >= DEPTH);
    if (act) begin
      if (!emp) m_dout = mq[m_rq].pop_front();
      m_stale = emp;
    end
    if (wr_en && whit && !wful) mq[wq].push_back(wr_data);
    if (rd_addr_en) begin
      m_rq = rd_addr[QW-1:0];
      m_hit = (rd_addr[ADDR_W-1:QW] == '0);
      m_phase = 1;
    end else if (m_phase == 1) m_phase = 2;
    else m_phase = 0;
    if (wr_addr_en) m_wa = wr_addr;
  endtask

  task automatic model_cmp();
    logic [DATA_W-1:0] ed;
    ed = m_hit ? m_dout : '0;
    checks++;
    if (q_data !== ed || out_stale !== (m_hit & m_stale) || q_drive !== m_hit) begin
      fails++;
      $display("FAIL R4 model: actual data=%h stale=%b drive=%b expected data=%h stale=%b drive=%b",
               q_data, out_stale, q_drive, ed, m_hit & m_stale, m_hit);
    end
  endtask

  // Drive at the falling edge, update model at the rising edge, compare at the next fall
  task automatic step(input logic wae, input logic [ADDR_W-1:0] wa, input logic we,
                      input logic [DATA_W-1:0] wd, input logic rae,
                      input logic [ADDR_W-1:0] ra, input logic re);
    wr_addr_en = wae; wr_addr = wa; wr_en = we; wr_data = wd;
    rd_addr_en = rae; rd_addr = ra; rd_en = re;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    model_cmp();
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, '0, 0);
  endtask

  task automatic expect_out(input string tag, input logic [DATA_W-1:0] ed,
                            input logic es, input logic edrv);
    checks++;
    if (q_data !== ed || out_stale !== es || q_drive !== edrv) begin
      fails++;
      $display("FAIL %s: actual data=%h stale=%b drive=%b expected data=%h stale=%b drive=%b",
               tag, q_data, out_stale, q_drive, ed, es, edrv);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog: actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    expect_out("R1 reset", '0, 1'b1, 1'b1);

    // R8: write into selected empty queue falls through next edge
    step(0, '0, 1, 18'h001A5, 0, '0, 0);
    expect_out("R8 write edge", '0, 1'b1, 1'b1);
    idle();
    expect_out("R8 fall through", 18'h001A5, 1'b0, 1'b1);

    // R9: no read, word holds
    for (int i = 0; i < 3; i++) begin
      idle();
      expect_out("R9 hold", 18'h001A5, 1'b0, 1'b1);
    end

    // R6 / R7: read last word, flag rises, word stays
    step(0, '0, 0, '0, 0, '0, 1);
    expect_out("R6 read to empty", 18'h001A5, 1'b1, 1'b1);
    for (int i = 0; i < 2; i++) begin
      idle();
      expect_out("R7 stays stale", 18'h001A5, 1'b1, 1'b1);
    end

    // R2: write with foreign device number is dropped
    step(1, {2'd1, 3'd0}, 0, '0, 0, '0, 0);
    step(0, '0, 1, 18'h000BB, 0, '0, 0);
    step(1, {2'd0, 3'd0}, 0, '0, 0, '0, 0);
    idle();
    expect_out("R2 foreign write ignored", 18'h001A5, 1'b1, 1'b1);

    // R5: switch latency two edges, rd_en ignored meanwhile
    step(1, {2'd0, 3'd3}, 0, '0, 0, '0, 0);
    step(0, '0, 1, 18'h00111, 0, '0, 0);
    step(0, '0, 1, 18'h00222, 0, '0, 0);
    step(0, '0, 0, '0, 1, {2'd0, 3'd3}, 0);
    expect_out("R5 at strobe", 18'h001A5, 1'b1, 1'b1);
    step(0, '0, 0, '0, 0, '0, 1);
    expect_out("R5 first wait", 18'h001A5, 1'b1, 1'b1);
    idle();
    expect_out("R5 head after two", 18'h00111, 1'b0, 1'b1);
    step(0, '0, 0, '0, 0, '0, 1);
    expect_out("R4 order", 18'h00222, 1'b0, 1'b1);
    step(0, '0, 0, '0, 0, '0, 1);
    expect_out("R6 last of q3", 18'h00222, 1'b1, 1'b1);

    // R3: overfill queue 5, exactly DEPTH come back
    step(1, {2'd0, 3'd5}, 0, '0, 0, '0, 0);
    for (int i = 0; i < DEPTH + 3; i++) step(0, '0, 1, DATA_W'(18'h300 + i), 0, '0, 0);
    step(0, '0, 0, '0, 1, {2'd0, 3'd5}, 0);
    idle();
    idle();
    expect_out("R3 head", 18'h00300, 1'b0, 1'b1);
    for (int i = 1; i < DEPTH; i++) begin
      step(0, '0, 0, '0, 0, '0, 1);
      expect_out("R3 drain", DATA_W'(18'h300 + i), 1'b0, 1'b1);
    end
    step(0, '0, 0, '0, 0, '0, 1);
    expect_out("R3 no extra word", DATA_W'(18'h300 + DEPTH - 1), 1'b1, 1'b1);

    // R10: release bus, reads while released take nothing
    step(1, {2'd0, 3'd6}, 0, '0, 0, '0, 0);
    step(0, '0, 1, 18'h0003A, 0, '0, 0);
    step(0, '0, 1, 18'h0003B, 1, {2'd0, 3'd6}, 0);
    idle();
    idle();
    expect_out("R10 setup head", 18'h0003A, 1'b0, 1'b1);
    step(0, '0, 0, '0, 1, {2'd1, 3'd6}, 0);
    expect_out("R10 released", '0, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) begin
      step(0, '0, 0, '0, 0, '0, 1);
      expect_out("R10 released read", '0, 1'b0, 1'b0);
    end
    step(0, '0, 0, '0, 1, {2'd0, 3'd6}, 0);
    expect_out("R10 reclaimed", 18'h0003A, 1'b0, 1'b1);
    idle();
    idle();
    expect_out("R10 no words lost", 18'h0003B, 1'b0, 1'b1);

    // Random traffic against the model (R4 and the rest)
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] wa, ra;
      wa = {(($urandom % 8) == 0) ? 2'd1 : 2'd0, 3'($urandom % NQ)};
      ra = {(($urandom % 10) == 0) ? 2'd1 : 2'd0, 3'($urandom % NQ)};
      step(($urandom % 10) == 0, wa, ($urandom % 2) == 0, DATA_W'($urandom),
           ($urandom % 20) == 0, ra, ($urandom % 5) < 2);
    end

    summary();
    $finish;
  end
endmodule